// File: doc/BRIEF.md
# Serial NOR Flash Probe and Protection Clear

This block runs a single start-up sequence on an SPI NOR flash. After reset it waits with chip select high. It then reads the three identification bytes the part returns to the standard JEDEC identification command. It checks the maker and memory-type codes against the one family it supports, and maps the capacity code to an erase-sector geometry. When the part is recognised, it clears the part's block-protection bits with a two-frame status-register write sequence.

The results go to the rest of the chip as registered outputs:
- an accepted flag,
- a rejected flag,
- the log2 of the erase-sector size,
- the number of erase sectors.

A one-cycle done pulse marks the end of the sequence. The block drives the SPI pins (mode 0, most significant bit first) only until that pulse. After it, chip select stays high and the clock stays low, so a data-transfer engine can take over the bus. When the read-only parameter is set, the block probes and reports as usual but never writes the status register.

Top module: `flash_probe_unlock`

## Requirements
- R1: While reset is applied and until the first frame starts, chip select is high, the serial clock is low, and the done pulse, both flags and both geometry outputs are zero. Chip select stays high for at least GAP_CYCLES clock cycles before each frame.
- R2: The first frame is four bytes long. Its first byte is the identification opcode 0x9F, sent most significant bit first in SPI mode 0 (clock idles low, data sampled on the rising edge). The three bytes the flash returns during the remaining three byte times are taken, in order, as maker code, memory-type code and capacity code.
- R3: The part is accepted only when the maker code is 0xBF and the memory-type code is 0x25. Any other maker or type code rejects it. The accepted and rejected flags are never both high.
- R4: An accepted part with capacity code 0x4A reports a sector shift of 12 and a sector count of 1024.
- R5: An accepted part with capacity code 0x41 reports a sector shift of 12 and a sector count of 512.
- R6: A rejected part, including a matching maker and type with any other capacity code, raises the rejected flag and reports zero geometry. No frame follows the identification frame.
- R7: After an accepted probe (read-only off), exactly two more frames follow, each inside its own chip-select window. The first is the single byte 0x50. The second is 0x01 followed by the status value 0x00.
- R8: The done pulse lasts exactly one cycle and appears exactly once per reset, whether the part is accepted or rejected. The flags and geometry become valid in that same cycle and hold until the next reset. No frame starts after the pulse.
- R9: With READ_ONLY set, an accepted part reports the same geometry as R4/R5, but only the identification frame is sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset; restarts the sequence |
| spi_sck | output | 1 | Serial clock to the flash, idle low |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |
| probe_done | output | 1 | One-cycle pulse when the sequence ends |
| part_ok | output | 1 | Part recognised and geometry valid |
| part_bad | output | 1 | Part not recognised |
| sector_shift | output | 5 | log2 of erase-sector size in bytes |
| sector_count | output | 11 | Number of erase sectors |

## Verification
The identification codes are driven from a behavioural flash that rebuilds every byte and frame boundary from the pins. Two codes of the supported family separate the two geometries from each other. A wrong maker code and a wrong memory-type code each on their own show that both fields take part in the acceptance test. A correct maker and type with an unknown capacity code shows that the capacity must match as well before any write frame is sent. A read-only instance runs beside the main one on every pattern, which separates the unlock decision from the geometry decode.

// File: rtl/flash_probe_pkg.sv
package flash_probe_pkg;

    localparam int SHIFT_W = 5;
    localparam int COUNT_W = 11;

    localparam logic [7:0] OP_READ_ID    = 8'h9F;
    localparam logic [7:0] OP_STAT_WREN  = 8'h50;
    localparam logic [7:0] OP_STAT_WRITE = 8'h01;
    localparam logic [7:0] STAT_CLEARED  = 8'h00;
    localparam logic [7:0] FILL_BYTE     = 8'hFF;

    localparam logic [7:0] MAKER_CODE = 8'hBF;
    localparam logic [7:0] TYPE_CODE  = 8'h25;
    localparam logic [7:0] CAP_BIG    = 8'h4A;
    localparam logic [7:0] CAP_SMALL  = 8'h41;

    localparam logic [SHIFT_W-1:0] SHIFT_4K = SHIFT_W'(12);

    typedef enum logic [1:0] {
        FR_IDENT,
        FR_WREN,
        FR_WRITE
    } frame_e;

    typedef enum logic [2:0] {
        ST_GAP,
        ST_LOAD,
        ST_WAIT,
        ST_CHECK,
        ST_FIN,
        ST_DONE
    } seq_state_e;

    typedef struct packed {
        logic               ok;
        logic [SHIFT_W-1:0] shift;
        logic [COUNT_W-1:0] count;
    } geom_t;

    function automatic logic [1:0] frame_last(input frame_e f);
        case (f)
            FR_IDENT: return 2'd3;
            FR_WREN:  return 2'd0;
            default:  return 2'd1;
        endcase
    endfunction

    function automatic logic [7:0] frame_byte(input frame_e f, input logic [1:0] i);
        case (f)
            FR_IDENT: return (i == 2'd0) ? OP_READ_ID : FILL_BYTE;
            FR_WREN:  return OP_STAT_WREN;
            default:  return (i == 2'd0) ? OP_STAT_WRITE : STAT_CLEARED;
        endcase
    endfunction

    function automatic geom_t decode_id(input logic [7:0] maker,
                                        input logic [7:0] kind,
                                        input logic [7:0] cap);
        geom_t g;
        g = '0;
        if (maker == MAKER_CODE && kind == TYPE_CODE) begin
            case (cap)
                CAP_BIG: begin
                    g.ok    = 1'b1;
                    g.shift = SHIFT_4K;
                    g.count = COUNT_W'(1024);
                end
                CAP_SMALL: begin
                    g.ok    = 1'b1;
                    g.shift = SHIFT_4K;
                    g.count = COUNT_W'(512);
                end
                default: g = '0;
            endcase
        end
        return g;
    endfunction

endpackage

// File: rtl/spi_byte_engine.sv
module spi_byte_engine #(
    parameter int HALF_DIV = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic [7:0] tx_byte,
    output logic       done,
    output logic [7:0] rx_byte,
    output logic       sck,
    output logic       mosi,
    input  logic       miso
);
    localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [DIV_W-1:0] DIV_TOP = DIV_W'(HALF_DIV - 1);

    logic             active;
    logic [DIV_W-1:0] div_cnt;
    logic [2:0]       bit_idx;
    logic [7:0]       sh_tx;
    logic [7:0]       sh_rx;

    always_ff @(posedge clk) begin
        if (rst) begin
            active  <= 1'b0;
            div_cnt <= '0;
            bit_idx <= '0;
            sh_tx   <= '0;
            sh_rx   <= '0;
            sck     <= 1'b0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!active) begin
                sck <= 1'b0;
                if (start) begin
                    active  <= 1'b1;
                    sh_tx   <= tx_byte;
                    div_cnt <= '0;
                    bit_idx <= '0;
                end
            end else if (div_cnt == DIV_TOP) begin
                div_cnt <= '0;
                if (!sck) begin
                    sck   <= 1'b1;
                    sh_rx <= {sh_rx[6:0], miso};
                end else begin
                    sck   <= 1'b0;
                    sh_tx <= {sh_tx[6:0], 1'b0};
                    if (bit_idx == 3'd7) begin
                        active <= 1'b0;
                        done   <= 1'b1;
                    end else begin
                        bit_idx <= bit_idx + 3'd1;
                    end
                end
            end else begin
                div_cnt <= div_cnt + 1'b1;
            end
        end
    end

    assign mosi    = active ? sh_tx[7] : 1'b0;
    assign rx_byte = sh_rx;

    AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        start |-> !active);                                   // R2
    AST_DONE_ON_LOW_CLOCK: assert property (@(posedge clk) disable iff (rst)
        done |-> (!sck && !active));                          // R2

endmodule

// File: rtl/id_decoder.sv
module id_decoder
    import flash_probe_pkg::*;
(
    input  logic [7:0] maker,
    input  logic [7:0] kind,
    input  logic [7:0] cap,
    output geom_t      geom
);
    always_comb begin
        geom = decode_id(maker, kind, cap);
    end
endmodule

// File: rtl/probe_sequencer.sv
module probe_sequencer
    import flash_probe_pkg::*;
#(
    parameter int GAP_CYCLES = 4,
    parameter bit READ_ONLY  = 1'b0
) (
    input  logic               clk,
    input  logic               rst,
    output logic               eng_start,
    output logic [7:0]         eng_tx,
    input  logic               eng_done,
    input  logic [7:0]         eng_rx,
    output logic               cs_n,
    output logic [7:0]         cap_maker,
    output logic [7:0]         cap_kind,
    output logic [7:0]         cap_size,
    input  geom_t              dec,
    output logic               probe_done,
    output logic               part_ok,
    output logic               part_bad,
    output logic [SHIFT_W-1:0] sector_shift,
    output logic [COUNT_W-1:0] sector_count
);
    localparam int GAP_W = $clog2(GAP_CYCLES + 1);
    localparam logic [GAP_W-1:0] GAP_TOP = GAP_W'(GAP_CYCLES - 1);

    seq_state_e       state;
    frame_e           frame;
    logic [1:0]       idx;
    logic [GAP_W-1:0] gap_cnt;
    geom_t            pend;
    logic             unlock_en;

    generate
        if (READ_ONLY) begin : g_ro
            assign unlock_en = 1'b0;
        end else begin : g_rw
            assign unlock_en = 1'b1;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            state        <= ST_GAP;
            frame        <= FR_IDENT;
            idx          <= '0;
            gap_cnt      <= '0;
            cs_n         <= 1'b1;
            eng_start    <= 1'b0;
            eng_tx       <= '0;
            cap_maker    <= '0;
            cap_kind     <= '0;
            cap_size     <= '0;
            pend         <= '0;
            probe_done   <= 1'b0;
            part_ok      <= 1'b0;
            part_bad     <= 1'b0;
            sector_shift <= '0;
            sector_count <= '0;
        end else begin
            eng_start  <= 1'b0;
            probe_done <= 1'b0;
            case (state)
                ST_GAP: begin
                    cs_n <= 1'b1;
                    if (gap_cnt == GAP_TOP) begin
                        gap_cnt <= '0;
                        idx     <= '0;
                        state   <= ST_LOAD;
                    end else begin
                        gap_cnt <= gap_cnt + 1'b1;
                    end
                end
                ST_LOAD: begin
                    cs_n      <= 1'b0;
                    eng_start <= 1'b1;
                    eng_tx    <= frame_byte(frame, idx);
                    state     <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (eng_done) begin
                        if (frame == FR_IDENT) begin
                            case (idx)
                                2'd1:    cap_maker <= eng_rx;
                                2'd2:    cap_kind  <= eng_rx;
                                2'd3:    cap_size  <= eng_rx;
                                default: ;
                            endcase
                        end
                        if (idx == frame_last(frame)) begin
                            cs_n <= 1'b1;
                            case (frame)
                                FR_IDENT: state <= ST_CHECK;
                                FR_WREN: begin
                                    frame <= FR_WRITE;
                                    state <= ST_GAP;
                                end
                                default:  state <= ST_FIN;
                            endcase
                        end else begin
                            idx   <= idx + 2'd1;
                            state <= ST_LOAD;
                        end
                    end
                end
                ST_CHECK: begin
                    pend <= dec;
                    if (dec.ok && unlock_en) begin
                        frame <= FR_WREN;
                        state <= ST_GAP;
                    end else begin
                        state <= ST_FIN;
                    end
                end
                ST_FIN: begin
                    probe_done   <= 1'b1;
                    part_ok      <= pend.ok;
                    part_bad     <= !pend.ok;
                    sector_shift <= pend.shift;
                    sector_count <= pend.count;
                    state        <= ST_DONE;
                end
                default: begin
                    cs_n  <= 1'b1;
                    state <= ST_DONE;
                end
            endcase
        end
    end

    AST_UNLOCK_NEEDS_MATCH: assert property (@(posedge clk) disable iff (rst)
        (frame != FR_IDENT) |-> pend.ok);                       // R6
    AST_QUIET_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DONE) |-> (cs_n && !eng_start));            // R8
    AST_GAP_DESELECTED: assert property (@(posedge clk) disable iff (rst)
        (state == ST_GAP && gap_cnt != '0) |-> cs_n);            // R1

endmodule

// File: rtl/flash_probe_unlock.sv
module flash_probe_unlock
    import flash_probe_pkg::*;
#(
    parameter int HALF_DIV   = 2,
    parameter int GAP_CYCLES = 4,
    parameter bit READ_ONLY  = 1'b0
) (
    input  logic               clk,
    input  logic               rst,
    output logic               spi_sck,
    output logic               spi_cs_n,
    output logic               spi_mosi,
    input  logic               spi_miso,
    output logic               probe_done,
    output logic               part_ok,
    output logic               part_bad,
    output logic [SHIFT_W-1:0] sector_shift,
    output logic [COUNT_W-1:0] sector_count
);
    logic       eng_start;
    logic       eng_done;
    logic [7:0] eng_tx;
    logic [7:0] eng_rx;
    logic [7:0] id_maker;
    logic [7:0] id_kind;
    logic [7:0] id_size;
    geom_t      dec_geom;

    spi_byte_engine #(.HALF_DIV(HALF_DIV)) u_engine (
        .clk     (clk),
        .rst     (rst),
        .start   (eng_start),
        .tx_byte (eng_tx),
        .done    (eng_done),
        .rx_byte (eng_rx),
        .sck     (spi_sck),
        .mosi    (spi_mosi),
        .miso    (spi_miso)
    );

    id_decoder u_decode (
        .maker (id_maker),
        .kind  (id_kind),
        .cap   (id_size),
        .geom  (dec_geom)
    );

    probe_sequencer #(
        .GAP_CYCLES (GAP_CYCLES),
        .READ_ONLY  (READ_ONLY)
    ) u_seq (
        .clk          (clk),
        .rst          (rst),
        .eng_start    (eng_start),
        .eng_tx       (eng_tx),
        .eng_done     (eng_done),
        .eng_rx       (eng_rx),
        .cs_n         (spi_cs_n),
        .cap_maker    (id_maker),
        .cap_kind     (id_kind),
        .cap_size     (id_size),
        .dec          (dec_geom),
        .probe_done   (probe_done),
        .part_ok      (part_ok),
        .part_bad     (part_bad),
        .sector_shift (sector_shift),
        .sector_count (sector_count)
    );

    AST_CLOCK_IDLE_DESELECTED: assert property (@(posedge clk) disable iff (rst)
        spi_cs_n |-> !spi_sck);                                  // R2
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        probe_done |=> !probe_done);                             // R8
    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(part_ok && part_bad));                                 // R3
    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (rst)
        (part_ok || part_bad) |=> $stable({part_ok, part_bad, sector_shift, sector_count})); // R8
    AST_REJECT_NO_GEOMETRY: assert property (@(posedge clk) disable iff (rst)
        part_bad |-> (sector_count == '0 && sector_shift == '0)); // R6

endmodule

// File: tb/flash_probe_unlock_test.sv
`timescale 1ns/1ps

module flash_probe_unlock_flashmodel #(
    parameter int MIN_GAP = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cs_n,
    input  logic       sck,
    input  logic       mosi,
    output logic       miso,
    input  logic [7:0] id_a,
    input  logic [7:0] id_b,
    input  logic [7:0] id_c
);
    int         nframes;
    int         gap_viol;
    int         stray;
    int         bitcnt;
    int         bytecnt;
    int         hi_cycles;
    int         flen [8];
    logic [7:0] fbytes [8][4];
    logic [7:0] cur;
    logic [7:0] rsp;
    logic       prev_sck;
    logic       prev_cs;

    always @(posedge clk) begin
        if (rst) begin
            nframes   = 0;
            gap_viol  = 0;
            stray     = 0;
            bitcnt    = 0;
            bytecnt   = 0;
            hi_cycles = 0;
            prev_sck  = 1'b0;
            prev_cs   = 1'b1;
            cur       = '0;
            miso     <= 1'b0;
            for (int i = 0; i < 8; i++) begin
                flen[i] = 0;
                for (int j = 0; j < 4; j++) fbytes[i][j] = '0;
            end
        end else begin
            if (cs_n && sck) stray++;
            if (prev_cs && !cs_n) begin
                if (hi_cycles < MIN_GAP) gap_viol++;
                bitcnt  = 0;
                bytecnt = 0;
            end
            if (cs_n) hi_cycles++; else hi_cycles = 0;
            if (!cs_n && !prev_sck && sck) begin
                cur = {cur[6:0], mosi};
                bitcnt++;
                if (bitcnt == 8) begin
                    if (bytecnt < 4 && nframes < 8) fbytes[nframes][bytecnt] = cur;
                    bytecnt++;
                    bitcnt = 0;
                end
            end
            if (!cs_n && prev_sck && !sck) begin
                rsp = 8'h00;
                if (nframes < 8 && bytecnt >= 1 && fbytes[nframes][0] == 8'h9F) begin
                    case (bytecnt)
                        1: rsp = id_a;
                        2: rsp = id_b;
                        3: rsp = id_c;
                        default: rsp = 8'h00;
                    endcase
                end
                miso <= rsp[7 - bitcnt];
            end
            if (!prev_cs && cs_n) begin
                if (nframes < 8) flen[nframes] = bytecnt;
                nframes++;
            end
            prev_sck = sck;
            prev_cs  = cs_n;
        end
    end
endmodule

module flash_probe_unlock_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  id_a = 8'h00;
    logic [7:0]  id_b = 8'h00;
    logic [7:0]  id_c = 8'h00;

    logic        sck0, cs0, mosi0, miso0, done0, ok0, bad0;
    logic [4:0]  shift0;
    logic [10:0] count0;
    logic        sck1, cs1, mosi1, miso1, done1, ok1, bad1;
    logic [4:0]  shift1;
    logic [10:0] count1;

    int checks = 0;
    int fails  = 0;
    int dcnt0  = 0;
    int dcnt1  = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    flash_probe_unlock #(.HALF_DIV(2), .GAP_CYCLES(4), .READ_ONLY(1'b0)) uut (
        .clk(clk), .rst(rst), .spi_sck(sck0), .spi_cs_n(cs0), .spi_mosi(mosi0),
        .spi_miso(miso0), .probe_done(done0), .part_ok(ok0), .part_bad(bad0),
        .sector_shift(shift0), .sector_count(count0));

    flash_probe_unlock #(.HALF_DIV(2), .GAP_CYCLES(4), .READ_ONLY(1'b1)) uut_ro (
        .clk(clk), .rst(rst), .spi_sck(sck1), .spi_cs_n(cs1), .spi_mosi(mosi1),
        .spi_miso(miso1), .probe_done(done1), .part_ok(ok1), .part_bad(bad1),
        .sector_shift(shift1), .sector_count(count1));

    flash_probe_unlock_flashmodel #(.MIN_GAP(4)) m0 (
        .clk(clk), .rst(rst), .cs_n(cs0), .sck(sck0), .mosi(mosi0), .miso(miso0),
        .id_a(id_a), .id_b(id_b), .id_c(id_c));
    flash_probe_unlock_flashmodel #(.MIN_GAP(4)) m1 (
        .clk(clk), .rst(rst), .cs_n(cs1), .sck(sck1), .mosi(mosi1), .miso(miso1),
        .id_a(id_a), .id_b(id_b), .id_c(id_c));

    always @(posedge clk) begin
        if (rst) dcnt0 <= 0; else if (done0) dcnt0 <= dcnt0 + 1;
    end
    always @(posedge clk) begin
        if (rst) dcnt1 <= 0; else if (done1) dcnt1 <= dcnt1 + 1;
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == 150000) begin
            $display("FAIL watchdog: run did not finish, actual=%0d cycles expected<150000", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks + 1, fails + 1);
            $finish;
        end
    end

    task automatic check(input bit cond, input string req, input longint act, input longint exp);
        checks++;
        if (!cond) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic apply_reset(input logic [7:0] a, input logic [7:0] b, input logic [7:0] c);
        id_a = a; id_b = b; id_c = c;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: state while held in reset
        check(cs0 == 1'b1 && cs1 == 1'b1, "R1 cs_n high in reset", {cs0, cs1}, 2'b11);
        check(sck0 == 1'b0 && sck1 == 1'b0, "R1 sck low in reset", {sck0, sck1}, 0);
        check({done0, ok0, bad0, shift0, count0} == '0, "R1 outputs zero in reset",
              {done0, ok0, bad0, shift0, count0}, 0);
        rst = 1'b0;
    endtask

    task automatic run_case(input logic [7:0] a, input logic [7:0] b, input logic [7:0] c,
                            input bit exp_ok, input int exp_count, input string req);
        bit seen0, seen1;
        int exp_shift;
        int frames_hold;
        exp_shift = exp_ok ? 12 : 0;
        seen0 = 0;
        seen1 = 0;
        apply_reset(a, b, c);
        for (int k = 0; k < 4000 && !(seen0 && seen1); k++) begin
            @(negedge clk);
            if (!seen0 && done0) begin
                seen0 = 1;
                check(ok0 == exp_ok && bad0 == !exp_ok, {req, " flags at done"}, {ok0, bad0}, {exp_ok, !exp_ok});
                check(shift0 == exp_shift, {req, " sector shift"}, shift0, exp_shift);
                check(count0 == exp_count, {req, " sector count"}, count0, exp_count);
            end
            if (!seen1 && done1) begin
                seen1 = 1;
                // R9: read-only instance reports the same geometry
                check(ok1 == exp_ok && count1 == exp_count && shift1 == exp_shift,
                      "R9 read-only geometry", {ok1, shift1, count1}, {exp_ok, 5'(exp_shift), 11'(exp_count)});
            end
        end
        check(seen0 && seen1, "R8 done pulse seen", {seen0, seen1}, 2'b11);
        // R2: identification frame
        check(m0.flen[0] == 4, "R2 ident frame length", m0.flen[0], 4);
        check(m0.fbytes[0][0] == 8'h9F, "R2 ident opcode", m0.fbytes[0][0], 8'h9F);
        check(m0.gap_viol == 0 && m0.stray == 0, "R1 deselect gap and idle clock",
              m0.gap_viol + m0.stray, 0);
        if (exp_ok) begin
            // R7: unlock frames
            check(m0.nframes == 3, "R7 frame count after accept", m0.nframes, 3);
            check(m0.flen[1] == 1 && m0.fbytes[1][0] == 8'h50, "R7 enable frame",
                  {m0.flen[1][7:0], m0.fbytes[1][0]}, 16'h0150);
            check(m0.flen[2] == 2 && m0.fbytes[2][0] == 8'h01 && m0.fbytes[2][1] == 8'h00,
                  "R7 status write frame", {m0.flen[2][7:0], m0.fbytes[2][0], m0.fbytes[2][1]}, 24'h020100);
        end else begin
            // R6: no frame after a rejected probe
            check(m0.nframes == 1, "R6 only ident frame on reject", m0.nframes, 1);
        end
        check(m1.nframes == 1, "R9 read-only sends only ident frame", m1.nframes, 1);
        frames_hold = m0.nframes;
        repeat (300) @(negedge clk);
        // R8: held results, single pulse, quiet bus
        check(ok0 == exp_ok && bad0 == !exp_ok && count0 == exp_count && shift0 == exp_shift,
              "R8 results held", {ok0, bad0, count0}, {exp_ok, !exp_ok, 11'(exp_count)});
        check(dcnt0 == 1 && dcnt1 == 1, "R8 exactly one done pulse", {dcnt0[7:0], dcnt1[7:0]}, 16'h0101);
        check(m0.nframes == frames_hold && cs0 == 1'b1, "R8 no frame after done", m0.nframes, frames_hold);
    endtask

    task automatic case_big();
        run_case(8'hBF, 8'h25, 8'h4A, 1'b1, 1024, "R4");
    endtask

    task automatic case_small();
        run_case(8'hBF, 8'h25, 8'h41, 1'b1, 512, "R5");
    endtask

    task automatic case_wrong_maker();
        run_case(8'hC2, 8'h25, 8'h4A, 1'b0, 0, "R3 maker");
    endtask

    task automatic case_wrong_type();
        run_case(8'hBF, 8'h26, 8'h41, 1'b0, 0, "R3 type");
    endtask

    task automatic case_unknown_size();
        run_case(8'hBF, 8'h25, 8'h42, 1'b0, 0, "R6 capacity");
    endtask

    initial begin
        case_big();
        case_small();
        case_wrong_maker();
        case_wrong_type();
        case_unknown_size();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule